// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether an I2C slave answers the address phase of a transfer. A bit-level front end that is not part of the block reports START (or repeated START) and STOP conditions and hands over each received byte with a one-cycle strobe. The matcher takes the first byte after a START as the address byte. When that byte carries the 10-bit header, it also takes the byte that follows. It then compares the result against two programmable 10-bit slave addresses. A 3-bit mode input sets how each of the two addresses is used: as a 7-bit address, as a 10-bit address, as unused, or as one end of an inclusive range.

The general call address and the SMBus alert response address are each matched only while their enable input is high. Every kind of match drives its own flag. The flags hold until the next START or STOP. Their OR is offered as the respond decision. On any match the block also stores the received address and the read/write bit in an 11-bit capture word. At the same time it raises an address-valid flag, and it drives a not-valid indicator that is the inverse of that flag. A read strobe from the register side clears the address-valid flag.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset every match flag, respond_o and addr_valid_o are 0, addr_nv_o is 1 and addr_cap_o is 0.
- R2: Only the first byte after a START, plus the second byte when the first carries the 10-bit header, form the address. Bytes strobed before any START, after the address is complete, or in the same cycle as start_i or stop_i are ignored.
- R3: The 10-bit header is a first byte whose bits 7:3 are 11110. Its bits 2:1 are address bits 9:8, bit 0 is the read/write bit, and the second byte gives address bits 7:0. Any other first byte is a 7-bit address: bits 7:1 are the address and bit 0 is the read/write bit.
- R4: match0_o sets when the received address equals addr0_i. In modes 0, 2 and 4 the comparison uses addr0_i[6:0] against a 7-bit address. In modes 1, 3 and 5 it uses all of addr0_i against a 10-bit address. In modes 6 and 7, match0_o never sets.
- R5: match1_o sets when the received address equals addr1_i. In modes 2 and 5 the comparison is 7-bit, using addr1_i[6:0]. In modes 3 and 4 it is 10-bit. In modes 0 and 1, addr1_i is unused.
- R6: In mode 6, match1_o sets for a 7-bit address A with addr0_i[6:0] <= A <= addr1_i[6:0]. In mode 7 it sets for a 10-bit address with addr0_i <= A <= addr1_i. Both ends are inclusive, and addr0_i is taken to be no greater than addr1_i.
- R7: gc_o sets for the 7-bit address 0x00 only while gc_en_i is 1.
- R8: alert_o sets for the 7-bit address 0x0C only while alert_en_i is 1.
- R9: When any flag sets, addr_cap_o takes {address[9:0], rw}, with a 7-bit address zero-extended, and addr_valid_o becomes 1. An address that matches nothing leaves addr_cap_o and addr_valid_o unchanged.
- R10: A stat_rd_i strobe clears addr_valid_o, which sets addr_nv_o, in the following cycle. A matching address that completes in the same cycle as the read wins: the valid flag stays set and the capture is updated.
- R11: start_i or stop_i clears all four match flags at the next edge. respond_o is the OR of the four flags.
- R12: Flags and the capture change at the clock edge that samples the byte strobe completing the address, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, MSB first on the bus |
| mode_i | input | 3 | Address match mode, encodings 0 to 7 |
| addr0_i | input | 10 | Slave address 0 |
| addr1_i | input | 10 | Slave address 1 or range upper bound |
| gc_en_i | input | 1 | General call recognition enable |
| alert_en_i | input | 1 | Alert response address recognition enable |
| stat_rd_i | input | 1 | Capture read strobe, clears address valid |
| match0_o | output | 1 | Address 0 matched |
| match1_o | output | 1 | Address 1 or range matched |
| gc_o | output | 1 | General call matched |
| alert_o | output | 1 | Alert response address matched |
| respond_o | output | 1 | Any flag set |
| addr_valid_o | output | 1 | Capture holds an unread match |
| addr_nv_o | output | 1 | Capture not valid |
| addr_cap_o | output | 11 | Captured {address, rw} |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a capture read and a matching address that completes in the same cycle. The bench drives stat_rd_i together with the completing byte strobe and expects the valid flag to remain set, with the new capture in place. The second pair is a START and a byte strobe in the same cycle. The bench drives both together, expects the byte to be dropped, and then expects the next byte to be treated as the address. Around these directed cases, a seeded random sequence of frames sweeps all eight modes, both address widths, the range ends and the two special addresses, and compares every outcome with a bench model.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic [1:0] {SLOT_OFF, SLOT_7B, SLOT_10B} slot_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND, PH_DONE} phase_e;

  typedef struct packed {
    logic alert;
    logic gc;
    logic m1;
    logic m0;
  } hit_t;

  // role of address slot idx under a mode; range modes return SLOT_OFF here
  function automatic slot_kind_e slot_kind(input logic [2:0] mode, input logic idx);
    slot_kind_e k;
    k = SLOT_OFF;
    unique case (mode)
      3'd0: k = idx ? SLOT_OFF : SLOT_7B;
      3'd1: k = idx ? SLOT_OFF : SLOT_10B;
      3'd2: k = SLOT_7B;
      3'd3: k = SLOT_10B;
      3'd4: k = idx ? SLOT_10B : SLOT_7B;
      3'd5: k = idx ? SLOT_7B : SLOT_10B;
      default: k = SLOT_OFF;
    endcase
    return k;
  endfunction

  function automatic slot_kind_e range_kind(input logic [2:0] mode);
    slot_kind_e k;
    unique case (mode)
      3'd6: k = SLOT_7B;
      3'd7: k = SLOT_10B;
      default: k = SLOT_OFF;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              long_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rw_o
);
  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int HDR_W = BYTE_W - HI_W - 1;
  localparam int PAD_W = ADDR_W - (BYTE_W - 1);
  localparam logic [HDR_W-1:0] HDR_PAT = {{(HDR_W-1){1'b1}}, 1'b0};

  phase_e          phase_q;
  logic [HI_W-1:0] hi_q;
  logic            rw_q;
  logic            is_hdr;
  logic            take;

  assign is_hdr = (byte_i[BYTE_W-1 -: HDR_W] == HDR_PAT);
  assign take   = byte_valid_i && !start_i && !stop_i;

  always_comb begin
    done_o = 1'b0;
    long_o = 1'b0;
    addr_o = {{PAD_W{1'b0}}, byte_i[BYTE_W-1:1]};
    rw_o   = byte_i[0];
    if (take && phase_q == PH_FIRST && !is_hdr) begin
      done_o = 1'b1;
    end else if (take && phase_q == PH_SECOND) begin
      done_o = 1'b1;
      long_o = 1'b1;
      addr_o = {hi_q, byte_i};
      rw_o   = rw_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      hi_q    <= '0;
      rw_q    <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_FIRST;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
    end else if (byte_valid_i) begin
      unique case (phase_q)
        PH_FIRST: begin
          if (is_hdr) begin
            phase_q <= PH_SECOND;
            hi_q    <= byte_i[HI_W:1];
            rw_q    <= byte_i[0];
          end else begin
            phase_q <= PH_DONE;
          end
        end
        PH_SECOND: phase_q <= PH_DONE;
        default:   phase_q <= phase_q;
      endcase
    end
  end

  // a header byte never completes the address by itself
  assert_header_waits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && phase_q == PH_FIRST && is_hdr) |=> (phase_q == PH_SECOND));

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int                 ADDR_W     = 10,
  parameter int                 SHORT_W    = 7,
  parameter logic [SHORT_W-1:0] GC_ADDR    = 7'h00,
  parameter logic [SHORT_W-1:0] ALERT_ADDR = 7'h0C
) (
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic              gc_en_i,
  input  logic              alert_en_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  localparam int NSLOT = 2;
  localparam int PAD_W = ADDR_W - SHORT_W;

  logic [NSLOT-1:0] eq;
  logic             in_rng;
  logic [ADDR_W-1:0] lo, hi;
  slot_kind_e       rk;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [ADDR_W-1:0] ref_full;
    logic [ADDR_W-1:0] ref_short;
    slot_kind_e        k;
    assign ref_full  = (s == 0) ? addr0_i : addr1_i;
    assign ref_short = {{PAD_W{1'b0}}, ref_full[SHORT_W-1:0]};
    assign k         = slot_kind(mode_i, 1'(s));
    assign eq[s] = ((k == SLOT_7B)  && !long_i && (addr_i == ref_short)) ||
                   ((k == SLOT_10B) &&  long_i && (addr_i == ref_full));
  end

  assign rk = range_kind(mode_i);

  always_comb begin
    if (rk == SLOT_7B) begin
      lo = {{PAD_W{1'b0}}, addr0_i[SHORT_W-1:0]};
      hi = {{PAD_W{1'b0}}, addr1_i[SHORT_W-1:0]};
    end else begin
      lo = addr0_i;
      hi = addr1_i;
    end
    in_rng = (((rk == SLOT_7B) && !long_i) || ((rk == SLOT_10B) && long_i)) &&
             (addr_i >= lo) && (addr_i <= hi);
  end

  assign hit_o.m0    = eq[0];
  assign hit_o.m1    = eq[1] | in_rng;
  assign hit_o.gc    = gc_en_i && !long_i && (addr_i == {{PAD_W{1'b0}}, GC_ADDR});
  assign hit_o.alert = alert_en_i && !long_i && (addr_i == {{PAD_W{1'b0}}, ALERT_ADDR});

endmodule

// File: rtl/i2c_am_stat.sv
module i2c_am_stat
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            done_i,
  input  hit_t            hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic            rw_i,
  input  logic            rd_i,
  output hit_t            flags_o,
  output logic            valid_o,
  output logic [ADDR_W:0] cap_o
);
  logic any_hit;
  logic load;

  assign any_hit = hit_i.m0 | hit_i.m1 | hit_i.gc | hit_i.alert;
  assign load    = done_i && any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
    end else if (clear_i) begin
      flags_o <= '0;
    end else if (done_i) begin
      flags_o <= hit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cap_o   <= '0;
    end else if (load) begin
      valid_o <= 1'b1;
      cap_o   <= {addr_i, rw_i};
    end else if (rd_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load) |=> !valid_o);

  assert_hit_beats_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (valid_o && cap_o == $past({addr_i, rw_i})));

  assert_flags_cleared_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (flags_o == '0));

  assert_miss_keeps_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !any_hit) |=> $stable(cap_o));

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int                 BYTE_W     = 8,
  parameter int                 ADDR_W     = 10,
  parameter int                 SHORT_W    = 7,
  parameter logic [SHORT_W-1:0] GC_ADDR    = 7'h00,
  parameter logic [SHORT_W-1:0] ALERT_ADDR = 7'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic              gc_en_i,
  input  logic              alert_en_i,
  input  logic              stat_rd_i,
  output logic              match0_o,
  output logic              match1_o,
  output logic              gc_o,
  output logic              alert_o,
  output logic              respond_o,
  output logic              addr_valid_o,
  output logic              addr_nv_o,
  output logic [ADDR_W:0]   addr_cap_o
);
  logic              done;
  logic              long_addr;
  logic [ADDR_W-1:0] rx_addr;
  logic              rx_rw;
  hit_t              hit;
  hit_t              flags;

  i2c_am_seq #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .done_o       (done),
    .long_o       (long_addr),
    .addr_o       (rx_addr),
    .rw_o         (rx_rw)
  );

  i2c_am_cmp #(
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .GC_ADDR(GC_ADDR), .ALERT_ADDR(ALERT_ADDR)
  ) u_cmp (
    .mode_i     (mode_i),
    .addr0_i    (addr0_i),
    .addr1_i    (addr1_i),
    .gc_en_i    (gc_en_i),
    .alert_en_i (alert_en_i),
    .long_i     (long_addr),
    .addr_i     (rx_addr),
    .hit_o      (hit)
  );

  i2c_am_stat #(.ADDR_W(ADDR_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i | stop_i),
    .done_i  (done),
    .hit_i   (hit),
    .addr_i  (rx_addr),
    .rw_i    (rx_rw),
    .rd_i    (stat_rd_i),
    .flags_o (flags),
    .valid_o (addr_valid_o),
    .cap_o   (addr_cap_o)
  );

  assign match0_o  = flags.m0;
  assign match1_o  = flags.m1;
  assign gc_o      = flags.gc;
  assign alert_o   = flags.alert;
  assign respond_o = flags.m0 | flags.m1 | flags.gc | flags.alert;
  assign addr_nv_o = ~addr_valid_o;

  assert_gc_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gc_o) |-> $past(gc_en_i));

  assert_alert_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_o) |-> $past(alert_en_i));

  assert_flag_follows_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(respond_o) |-> ($past(byte_valid_i) && !$past(start_i) && !$past(stop_i)));

  assert_valid_follows_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_valid_o) |-> $past(byte_valid_i));

endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        start, stop, bv, rd, gce, ale;
  logic [7:0]  bt;
  logic [2:0]  mode;
  logic [9:0]  a0, a1;
  logic        m0, m1, gc, al, resp, val, nv;
  logic [10:0] cap;

  int checks = 0;
  int errors = 0;

  logic [3:0]  e_fl;
  logic        e_val;
  logic [10:0] e_cap;

  i2c_addr_match u_i2c_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bv), .byte_i(bt), .mode_i(mode), .addr0_i(a0), .addr1_i(a1),
    .gc_en_i(gce), .alert_en_i(ale), .stat_rd_i(rd),
    .match0_o(m0), .match1_o(m1), .gc_o(gc), .alert_o(al), .respond_o(resp),
    .addr_valid_o(val), .addr_nv_o(nv), .addr_cap_o(cap)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "flags", {28'd0, al, gc, m1, m0}, {28'd0, e_fl});
    chk(tag, "respond", {31'd0, resp}, {31'd0, |e_fl});
    chk(tag, "valid", {31'd0, val}, {31'd0, e_val});
    chk(tag, "nv", {31'd0, nv}, {31'd0, ~e_val});
    chk(tag, "cap", {21'd0, cap}, {21'd0, e_cap});
  endtask

  // {alert, gc, m1, m0}
  function automatic logic [3:0] model(input logic [2:0] md, input logic [9:0] x0,
      input logic [9:0] x1, input logic g, input logic a, input logic is10,
      input logic [9:0] ad);
    logic s, f0, f1;
    logic [9:0] s0, s1;
    s = !is10;
    s0 = {3'b0, x0[6:0]};
    s1 = {3'b0, x1[6:0]};
    f0 = 0; f1 = 0;
    case (md)
      3'd0: f0 = s && ad == s0;
      3'd1: f0 = is10 && ad == x0;
      3'd2: begin f0 = s && ad == s0;    f1 = s && ad == s1;    end
      3'd3: begin f0 = is10 && ad == x0; f1 = is10 && ad == x1; end
      3'd4: begin f0 = s && ad == s0;    f1 = is10 && ad == x1; end
      3'd5: begin f0 = is10 && ad == x0; f1 = s && ad == s1;    end
      3'd6: f1 = s && ad >= s0 && ad <= s1;
      default: f1 = is10 && ad >= x0 && ad <= x1;
    endcase
    return {a && s && ad == 10'h00C, g && s && ad == 10'h000, f1, f0};
  endfunction

  task automatic apply(input logic is10, input logic [9:0] ad, input logic rw);
    logic [3:0] f;
    f = model(mode, a0, a1, gce, ale, is10, ad);
    e_fl = f;
    if (|f) begin
      e_val = 1'b1;
      e_cap = {ad, rw};
    end
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    e_fl = '0;
  endtask

  task automatic pulse_stop;
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    e_fl = '0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin bv = 1'b1; bt = b; end
    @(negedge clk) bv = 1'b0;
  endtask

  task automatic do_read;
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    e_val = 1'b0;
  endtask

  task automatic frame(input logic is10, input logic [9:0] ad, input logic rw);
    pulse_start;
    if (is10) begin
      send({5'b11110, ad[9:8], rw});
      send(ad[7:0]);
    end else begin
      send({ad[6:0], rw});
    end
    apply(is10, ad, rw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; start = 0; stop = 0; bv = 0; rd = 0; gce = 0; ale = 0;
    bt = '0; mode = '0; a0 = '0; a1 = '0;
    e_fl = '0; e_val = 0; e_cap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // byte before any START is ignored
    mode = 3'd0; a0 = 10'h02A;
    send({7'h2A, 1'b0});
    check_all("R2");

    // R12: flags not set before the sampling edge
    pulse_start;
    @(negedge clk) begin bv = 1'b1; bt = {7'h2A, 1'b1}; end
    #2 chk("R12", "early", {31'd0, m0}, 32'd0);
    @(negedge clk) bv = 1'b0;
    apply(1'b0, 10'h02A, 1'b1);
    check_all("R4");
    chk("R3", "cap7", {21'd0, cap}, 32'h055);

    // trailing byte ignored
    send({7'h2B, 1'b0});
    check_all("R2");

    pulse_stop;
    check_all("R11");
    do_read;
    check_all("R10");

    // 10-bit slot 0
    mode = 3'd1; a0 = 10'h2A5;
    frame(1'b1, 10'h2A5, 1'b0);
    check_all("R3");
    chk("R4", "m0_10b", {31'd0, m0}, 32'd1);

    // slot 1
    mode = 3'd3; a1 = 10'h1C3;
    frame(1'b1, 10'h1C3, 1'b1);
    chk("R5", "m1_10b", {31'd0, m1}, 32'd1);
    check_all("R5");
    mode = 3'd2; a1 = 10'h051;
    frame(1'b0, 10'h051, 1'b0);
    check_all("R5");

    // 7-bit ranges
    mode = 3'd6; a0 = 10'h010; a1 = 10'h020;
    frame(1'b0, 10'h010, 1'b0); check_all("R6");
    chk("R6", "lo_m1", {31'd0, m1}, 32'd1);
    frame(1'b0, 10'h020, 1'b0); check_all("R6");
    frame(1'b0, 10'h021, 1'b0); check_all("R6");
    frame(1'b0, 10'h00F, 1'b0); check_all("R6");
    // 10-bit range
    mode = 3'd7; a0 = 10'h100; a1 = 10'h1FF;
    frame(1'b1, 10'h100, 1'b0); check_all("R6");
    frame(1'b1, 10'h1FF, 1'b1); check_all("R6");
    frame(1'b1, 10'h200, 1'b0); check_all("R6");

    // R9: miss leaves capture and valid
    frame(1'b1, 10'h300, 1'b1); check_all("R9");

    // general call / alert
    mode = 3'd0; a0 = 10'h055;
    gce = 0; frame(1'b0, 10'h000, 1'b0); check_all("R7");
    gce = 1; frame(1'b0, 10'h000, 1'b0); check_all("R7");
    chk("R7", "gc", {31'd0, gc}, 32'd1);
    ale = 0; frame(1'b0, 10'h00C, 1'b1); check_all("R8");
    ale = 1; frame(1'b0, 10'h00C, 1'b1); check_all("R8");
    chk("R8", "alert", {31'd0, al}, 32'd1);

    // START and byte in the same cycle: byte dropped, next byte is the address
    do_read;
    @(negedge clk) begin start = 1'b1; bv = 1'b1; bt = {7'h55, 1'b0}; end
    @(negedge clk) begin start = 1'b0; bv = 1'b0; end
    e_fl = '0;
    check_all("R2");
    send({7'h55, 1'b1});
    apply(1'b0, 10'h055, 1'b1);
    check_all("R2");

    // read and matching completion in the same cycle
    pulse_start;
    @(negedge clk) begin bv = 1'b1; bt = {7'h55, 1'b0}; rd = 1'b1; end
    @(negedge clk) begin bv = 1'b0; rd = 1'b0; end
    apply(1'b0, 10'h055, 1'b0);
    check_all("R10");
    chk("R10", "valid_kept", {31'd0, val}, 32'd1);

    // random frames
    for (int i = 0; i < 400; i++) begin
      logic       is10, rw;
      logic [9:0] ad;
      int         sel;
      mode = 3'($urandom);
      a0 = 10'($urandom); a1 = 10'($urandom);
      if (mode >= 3'd6) begin
        if (mode == 3'd6 && a0[6:0] > a1[6:0]) begin
          logic [9:0] t; t = a0; a0 = a1; a1 = t;
        end
        if (mode == 3'd7 && a0 > a1) begin
          logic [9:0] t; t = a0; a0 = a1; a1 = t;
        end
      end
      gce = 1'($urandom); ale = 1'($urandom);
      is10 = 1'($urandom); rw = 1'($urandom);
      sel = int'($urandom % 6);
      case (sel)
        0: ad = a0;
        1: ad = a1;
        2: ad = 10'h000;
        3: ad = 10'h00C;
        4: ad = 10'($urandom);
        default: ad = a0 + 10'd1;
      endcase
      if (!is10) begin
        ad = {3'b0, ad[6:0]};
        if (ad[6:2] == 5'b11110) ad = ad ^ 10'h004;
      end
      frame(is10, ad, rw);
      check_all(is10 ? "R3" : "R4");
      if ($urandom % 3 == 0) begin send(8'($urandom)); check_all("R2"); end
      if ($urandom % 3 == 0) begin do_read; check_all("R10"); end
      if ($urandom % 4 == 0) begin pulse_stop; check_all("R11"); end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule